// File: doc/BRIEF.md
# Multi-Mode Quadrature Encoder Counter

This block turns two already-filtered encoder lines, A and B, into an up/down position count. A four-bit mode code selects the decoding scheme at run time. It can decode true quadrature at x1, x2 or x4 resolution, where the direction comes from the level of the other channel. It can treat B as a count clock with A as a direction level. It can also treat A and B as separate up and down clocks. In the x1 variants, a polarity bit for each channel picks whether the rising or the falling edge counts.

Both inputs are registered once. Edges are found by comparing the registered value with the value one clock older, and the counter steps at most once per clock. The count wraps in both directions between zero and a programmable wrap value. A registered direction flag records the sense of the most recent counted step. Users normally hold the mode and polarity steady while the encoder is moving.

Top module: `qenc_top`

## Requirements
- R1: Synchronous active-high reset clears `count` to 0 and `dir_down` to 0. While reset is held, the input registers load the current line levels, so input levels present at release produce no step.
- R2: With `mode_sel` = 1, only edges of A count. The step is up when A after the edge differs from B, and down otherwise. Edges of B are ignored.
- R3: With `mode_sel` = 2, only edges of B count. The step is up when B after the edge equals A, and down otherwise. Edges of A are ignored.
- R4: With `mode_sel` = 3, edges of either channel count, each by its own rule from R2 and R3. A sample in which both A and B change gives no step.
- R5: With `mode_sel` = 14, only one edge type of A counts: rising when `pol_a` = 0, falling when `pol_a` = 1. The direction follows the R2 rule. With `mode_sel` = 15, the same applies to B with `pol_b` and the R3 rule.
- R6: With `mode_sel` = 10, both edges of B count. The step is down when A is high and up when A is low. Changes of A alone never count.
- R7: With `mode_sel` = 11, only one edge type of B counts (rising when `pol_b` = 0, falling when `pol_b` = 1). A sets the direction as in R6.
- R8: With `mode_sel` = 12, every edge of A steps up and every edge of B steps down. When A and B change in the same sample, the two cancel and there is no step.
- R9: With `mode_sel` = 13, only A edges of the type chosen by `pol_a` step up, and only B edges of the type chosen by `pol_b` step down. When both occur in the same sample, they cancel.
- R10: An up step from a count at or above `wrap_val` gives 0. A down step from 0 gives `wrap_val`. Any other step adds or subtracts one.
- R11: `dir_down` is written only on a counted step: 1 for down, 0 for up. Without a step, both `dir_down` and `count` hold.
- R12: Mode codes 0 and 4 to 9 never change `count`, whatever the inputs do.
- R13: An input change presented before clock edge k appears on `count` after clock edge k+1 and not after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 4 | Decoding scheme code |
| pol_a | input | 1 | A active edge in x1 modes: 0 rising, 1 falling |
| pol_b | input | 1 | B active edge in x1 modes: 0 rising, 1 falling |
| wrap_val | input | W | Highest count value before wrapping |
| enc_a | input | 1 | Filtered encoder line A |
| enc_b | input | 1 | Filtered encoder line B |
| count | output | W | Position count |
| dir_down | output | 1 | Direction of the last counted step, 1 = down |

## Verification
Each scheme is driven with full Gray-code walks in both rotation senses. These walks tell correct direction rules apart from swapped ones and show which channel a mode listens to. In the x1 modes, each walk is repeated with the polarity flipped, so the bench can tell rising-edge counting from falling-edge counting. Samples in which both lines toggle at once separate the cancel and no-step behaviour from a double count. Walks that cross zero and the wrap value, at a small and at a full-width wrap value, check both wrap directions. Changes of the non-clock line, and the reserved mode codes, show that ignored activity leaves both the count and the flag untouched.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [3:0] {
    M_OFF       = 4'd0,
    M_QUAD_A    = 4'd1,
    M_QUAD_B    = 4'd2,
    M_QUAD_AB   = 4'd3,
    M_CLKDIR_X2 = 4'd10,
    M_CLKDIR_X1 = 4'd11,
    M_UPDN_X2   = 4'd12,
    M_UPDN_X1   = 4'd13,
    M_QUAD_A_X1 = 4'd14,
    M_QUAD_B_X1 = 4'd15
  } qenc_mode_e;

  // Channel index within the synchronised input vector
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int NUM_CH = 2;

  // True for codes that never move the counter
  function automatic logic mode_is_idle(input logic [3:0] m);
    return (m == 4'd0) || ((m >= 4'd4) && (m <= 4'd9));
  endfunction

endpackage

// File: rtl/qenc_sample.sv
module qenc_sample #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] cur,
  output logic [NCH-1:0] prv
);

  // One capture stage plus one history stage per channel
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cur_q;
    logic prv_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q <= din[g];
        prv_q <= din[g];
      end else begin
        cur_q <= din[g];
        prv_q <= cur_q;
      end
    end

    assign cur[g] = cur_q;
    assign prv[g] = prv_q;
  end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic [3:0] mode_sel,
  input  logic       pol_a,
  input  logic       pol_b,
  input  logic       a_cur,
  input  logic       a_prv,
  input  logic       b_cur,
  input  logic       b_prv,
  output logic       step_up,
  output logic       step_dn
);

  logic edge_a, edge_b;
  logic act_a, act_b;
  logic quad_a_up, quad_b_up;

  always_comb begin
    edge_a    = a_cur ^ a_prv;
    edge_b    = b_cur ^ b_prv;
    // polarity 0 picks the rising edge, 1 the falling edge
    act_a     = edge_a & (a_cur ^ pol_a);
    act_b     = edge_b & (b_cur ^ pol_b);
    // A leading B counts up
    quad_a_up = a_cur ^ b_cur;
    quad_b_up = ~(a_cur ^ b_cur);
  end

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    case (mode_sel)
      M_QUAD_A: begin
        step_up = edge_a & quad_a_up;
        step_dn = edge_a & ~quad_a_up;
      end
      M_QUAD_B: begin
        step_up = edge_b & quad_b_up;
        step_dn = edge_b & ~quad_b_up;
      end
      M_QUAD_AB: begin
        if (edge_a && !edge_b) begin
          step_up = quad_a_up;
          step_dn = ~quad_a_up;
        end else if (edge_b && !edge_a) begin
          step_up = quad_b_up;
          step_dn = ~quad_b_up;
        end
      end
      M_QUAD_A_X1: begin
        step_up = act_a & quad_a_up;
        step_dn = act_a & ~quad_a_up;
      end
      M_QUAD_B_X1: begin
        step_up = act_b & quad_b_up;
        step_dn = act_b & ~quad_b_up;
      end
      M_CLKDIR_X2: begin
        step_up = edge_b & ~a_cur;
        step_dn = edge_b & a_cur;
      end
      M_CLKDIR_X1: begin
        step_up = act_b & ~a_cur;
        step_dn = act_b & a_cur;
      end
      M_UPDN_X2: begin
        step_up = edge_a & ~edge_b;
        step_dn = edge_b & ~edge_a;
      end
      M_UPDN_X1: begin
        step_up = act_a & ~act_b;
        step_dn = act_b & ~act_a;
      end
      default: begin
        step_up = 1'b0;
        step_dn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wrap_val,
  input  logic         step_up,
  input  logic         step_dn,
  output logic [W-1:0] count,
  output logic         dir_down
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic         dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      dir_q <= 1'b0;
    end else if (step_up) begin
      cnt_q <= (cnt_q >= wrap_val) ? ZERO : cnt_q + ONE;
      dir_q <= 1'b0;
    end else if (step_dn) begin
      cnt_q <= (cnt_q == ZERO) ? wrap_val : cnt_q - ONE;
      dir_q <= 1'b1;
    end
  end

  assign count    = cnt_q;
  assign dir_down = dir_q;

  // R10: upward wrap lands on zero
  a_r10_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (step_up && (cnt_q >= wrap_val)) |=> (cnt_q == ZERO));

  // R10: downward wrap lands on the wrap value
  a_r10_wrap_dn: assert property (@(posedge clk) disable iff (rst)
    (step_dn && !step_up && (cnt_q == ZERO)) |=> (cnt_q == $past(wrap_val)));

  // R11: no step keeps count and direction
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn) |=> ($stable(cnt_q) && $stable(dir_q)));

  // R11: a down step sets the flag, an up step clears it
  a_r11_dir_follow: assert property (@(posedge clk) disable iff (rst)
    step_dn && !step_up |=> dir_q);

endmodule

// File: rtl/qenc_top.sv
module qenc_top
  import qenc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   mode_sel,
  input  logic         pol_a,
  input  logic         pol_b,
  input  logic [W-1:0] wrap_val,
  input  logic         enc_a,
  input  logic         enc_b,
  output logic [W-1:0] count,
  output logic         dir_down
);

  logic [NUM_CH-1:0] lines;
  logic [NUM_CH-1:0] cur;
  logic [NUM_CH-1:0] prv;
  logic              step_up;
  logic              step_dn;

  assign lines[CH_A] = enc_a;
  assign lines[CH_B] = enc_b;

  qenc_sample #(.NCH(NUM_CH)) u_sample (
    .clk (clk),
    .rst (rst),
    .din (lines),
    .cur (cur),
    .prv (prv)
  );

  qenc_decode u_decode (
    .mode_sel (mode_sel),
    .pol_a    (pol_a),
    .pol_b    (pol_b),
    .a_cur    (cur[CH_A]),
    .a_prv    (prv[CH_A]),
    .b_cur    (cur[CH_B]),
    .b_prv    (prv[CH_B]),
    .step_up  (step_up),
    .step_dn  (step_dn)
  );

  qenc_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .wrap_val (wrap_val),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .count    (count),
    .dir_down (dir_down)
  );

  // At most one direction per clock
  a_r11_one_dir: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn));

  // R12: reserved and off codes leave the count alone
  a_r12_idle_mode: assert property (@(posedge clk) disable iff (rst)
    mode_is_idle(mode_sel) |=> $stable(count));

  // R4: simultaneous change of both lines gives no step in x4
  a_r4_both_no_step: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == M_QUAD_AB) && (cur[CH_A] != prv[CH_A]) && (cur[CH_B] != prv[CH_B]))
      |-> (!step_up && !step_dn));

  // R2: in A-only quadrature a quiet A line means no step
  a_r2_b_ignored: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == M_QUAD_A) && (cur[CH_A] == prv[CH_A])) |=> $stable(count));

  // R6: clock-plus-direction moves only on B activity
  a_r6_a_ignored: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == M_CLKDIR_X2) && (cur[CH_B] == prv[CH_B])) |-> (!step_up && !step_dn));

  // R8: cancel on simultaneous up and down clocks
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == M_UPDN_X2) && (cur[CH_A] != prv[CH_A]) && (cur[CH_B] != prv[CH_B]))
      |=> $stable(count));

endmodule

// File: tb/qenc_top_tb.sv
module qenc_top_tb;

  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 58;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   mode_sel = 4'd0;
  logic         pol_a = 1'b0;
  logic         pol_b = 1'b0;
  logic [W-1:0] wrap_val = 8'd5;
  logic         enc_a = 1'b0;
  logic         enc_b = 1'b0;
  logic [W-1:0] count;
  logic         dir_down;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_top #(.W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .pol_a    (pol_a),
    .pol_b    (pol_b),
    .wrap_val (wrap_val),
    .enc_a    (enc_a),
    .enc_b    (enc_b),
    .count    (count),
    .dir_down (dir_down)
  );

  // {mode, pol_a, pol_b, a, b, expected count, expected dir}, wrap value 5
  localparam logic [16:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b0},
    {4'd1, 1'b0,1'b0, 1'b1,1'b1, 8'd1, 1'b0},
    {4'd1, 1'b0,1'b0, 1'b0,1'b1, 8'd2, 1'b0},
    {4'd1, 1'b0,1'b0, 1'b0,1'b0, 8'd2, 1'b0},
    {4'd1, 1'b0,1'b0, 1'b0,1'b1, 8'd2, 1'b0},
    {4'd1, 1'b0,1'b0, 1'b1,1'b1, 8'd1, 1'b1},
    {4'd2, 1'b0,1'b0, 1'b0,1'b1, 8'd1, 1'b1},
    {4'd2, 1'b0,1'b0, 1'b0,1'b0, 8'd2, 1'b0},
    {4'd2, 1'b0,1'b0, 1'b1,1'b0, 8'd2, 1'b0},
    {4'd2, 1'b0,1'b0, 1'b1,1'b1, 8'd3, 1'b0},
    {4'd2, 1'b0,1'b0, 1'b0,1'b1, 8'd3, 1'b0},
    {4'd2, 1'b0,1'b0, 1'b0,1'b0, 8'd4, 1'b0},
    {4'd2, 1'b0,1'b0, 1'b0,1'b1, 8'd3, 1'b1},
    {4'd3, 1'b0,1'b0, 1'b0,1'b0, 8'd4, 1'b0},
    {4'd3, 1'b0,1'b0, 1'b1,1'b0, 8'd5, 1'b0},
    {4'd3, 1'b0,1'b0, 1'b1,1'b1, 8'd0, 1'b0},
    {4'd3, 1'b0,1'b0, 1'b0,1'b1, 8'd1, 1'b0},
    {4'd3, 1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b0},
    {4'd3, 1'b0,1'b0, 1'b1,1'b1, 8'd2, 1'b0},
    {4'd3, 1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b1},
    {4'd3, 1'b0,1'b0, 1'b0,1'b0, 8'd0, 1'b1},
    {4'd3, 1'b0,1'b0, 1'b0,1'b1, 8'd5, 1'b1},
    {4'd14,1'b0,1'b0, 1'b1,1'b1, 8'd4, 1'b1},
    {4'd14,1'b0,1'b0, 1'b0,1'b1, 8'd4, 1'b1},
    {4'd14,1'b0,1'b0, 1'b0,1'b0, 8'd4, 1'b1},
    {4'd14,1'b0,1'b0, 1'b1,1'b0, 8'd5, 1'b0},
    {4'd14,1'b1,1'b0, 1'b0,1'b0, 8'd4, 1'b1},
    {4'd14,1'b1,1'b0, 1'b1,1'b0, 8'd4, 1'b1},
    {4'd15,1'b0,1'b0, 1'b1,1'b1, 8'd5, 1'b0},
    {4'd15,1'b0,1'b0, 1'b1,1'b0, 8'd5, 1'b0},
    {4'd15,1'b0,1'b0, 1'b0,1'b0, 8'd5, 1'b0},
    {4'd15,1'b0,1'b0, 1'b0,1'b1, 8'd4, 1'b1},
    {4'd15,1'b0,1'b1, 1'b0,1'b0, 8'd5, 1'b0},
    {4'd10,1'b0,1'b0, 1'b0,1'b1, 8'd0, 1'b0},
    {4'd10,1'b0,1'b0, 1'b0,1'b0, 8'd1, 1'b0},
    {4'd10,1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b0},
    {4'd10,1'b0,1'b0, 1'b1,1'b1, 8'd0, 1'b1},
    {4'd10,1'b0,1'b0, 1'b1,1'b0, 8'd5, 1'b1},
    {4'd11,1'b0,1'b0, 1'b1,1'b1, 8'd4, 1'b1},
    {4'd11,1'b0,1'b0, 1'b1,1'b0, 8'd4, 1'b1},
    {4'd11,1'b0,1'b0, 1'b0,1'b0, 8'd4, 1'b1},
    {4'd11,1'b0,1'b0, 1'b0,1'b1, 8'd5, 1'b0},
    {4'd11,1'b0,1'b1, 1'b0,1'b0, 8'd0, 1'b0},
    {4'd12,1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b0},
    {4'd12,1'b0,1'b0, 1'b0,1'b0, 8'd2, 1'b0},
    {4'd12,1'b0,1'b0, 1'b0,1'b1, 8'd1, 1'b1},
    {4'd12,1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b1},
    {4'd12,1'b0,1'b0, 1'b1,1'b1, 8'd0, 1'b1},
    {4'd13,1'b0,1'b0, 1'b0,1'b1, 8'd0, 1'b1},
    {4'd13,1'b0,1'b0, 1'b1,1'b1, 8'd1, 1'b0},
    {4'd13,1'b0,1'b0, 1'b1,1'b0, 8'd1, 1'b0},
    {4'd13,1'b0,1'b0, 1'b1,1'b1, 8'd0, 1'b1},
    {4'd13,1'b1,1'b1, 1'b0,1'b1, 8'd1, 1'b0},
    {4'd13,1'b1,1'b1, 1'b0,1'b0, 8'd0, 1'b1},
    {4'd0, 1'b0,1'b0, 1'b1,1'b1, 8'd0, 1'b1},
    {4'd0, 1'b0,1'b0, 1'b0,1'b1, 8'd0, 1'b1},
    {4'd5, 1'b0,1'b0, 1'b1,1'b0, 8'd0, 1'b1},
    {4'd7, 1'b0,1'b0, 1'b1,1'b1, 8'd0, 1'b1}
  };

  function automatic string vec_tag(input int i);
    if (i < 6)  return "R2";
    if (i < 13) return "R3";
    if (i < 22) return "R4";
    if (i < 33) return "R5";
    if (i < 38) return "R6";
    if (i < 43) return "R7";
    if (i < 48) return "R8";
    if (i < 54) return "R9";
    return "R12";
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp_cnt, input logic exp_dir);
    n_checks++;
    if (count !== exp_cnt || dir_down !== exp_dir) begin
      n_fails++;
      $display("FAIL %s: count=%0d dir=%0d expected count=%0d dir=%0d",
               tag, count, dir_down, exp_cnt, exp_dir);
    end
  endtask

  // Drive at a falling edge, then let two rising edges pass
  task automatic apply(input logic [3:0] m, input logic pa, input logic pb,
                       input logic a, input logic b);
    mode_sel = m; pol_a = pa; pol_b = pb; enc_a = a; enc_b = b;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", 8'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][16:13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check(vec_tag(i), VEC[i][8:1], VEC[i][0]);
    end

    // R10: full-width wrap value, both directions (state a=1 b=1 count 0)
    wrap_val = 8'hFF;
    apply(4'd12, 1'b0, 1'b0, 1'b0, 1'b1); check("R10", 8'd1, 1'b0);
    apply(4'd12, 1'b0, 1'b0, 1'b0, 1'b0); check("R10", 8'd0, 1'b1);
    apply(4'd12, 1'b0, 1'b0, 1'b0, 1'b1); check("R10", 8'd255, 1'b1);
    apply(4'd12, 1'b0, 1'b0, 1'b1, 1'b1); check("R10", 8'd0, 1'b0);

    // R13: two-clock latency from input change to count
    enc_a = 1'b0;
    @(negedge clk);
    check("R13", 8'd0, 1'b0);
    @(negedge clk);
    check("R13", 8'd1, 1'b0);

    // R11: ignored edge after a down step keeps flag and count
    apply(4'd14, 1'b0, 1'b0, 1'b1, 1'b1); check("R11", 8'd0, 1'b1);
    apply(4'd14, 1'b0, 1'b0, 1'b0, 1'b1); check("R11", 8'd0, 1'b1);

    // R1: reset from a non-zero count with the flag set
    apply(4'd12, 1'b0, 1'b0, 1'b1, 1'b1); check("R1", 8'd1, 1'b0);
    apply(4'd12, 1'b0, 1'b0, 1'b1, 1'b0); check("R1", 8'd0, 1'b1);
    apply(4'd12, 1'b0, 1'b0, 1'b1, 1'b1); check("R1", 8'd255, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", 8'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R1", 8'd0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule